// File: doc/BRIEF.md
# Power Controller Pin Role and Power State Unit

This unit sits between the pads of a dual-rail power controller and its regulator and sequencer logic. A static 2-bit mode setting decides what each of four general pins (named A, B, C and D here) and one master input do. In direct mode, two pins switch the rails on and off on their own. In the two sequenced modes, a master pin hands control to an external sequencer and the pins report rail health. The unit also works out the device power state from the undervoltage flag, the sleep pin and, in one mode, a standby pin.

A reset output is built from the two power-good flags through a selectable boolean. Every output-capable pin can be set to open-drain or push-pull. Pad inputs and the sleep pin pass through a two-stage synchronizer. All outputs are registered. Configuration bits are treated as static.

Top module: `pmic_pin_ctrl`

## Requirements
- R1: `pwr_state` encodes 00 = off, 01 = on, 10 = sleep, 11 = standby. `uv_low` high gives off. Otherwise `sleep_in` high gives sleep. Otherwise, in mode 11 with pin A high, it gives standby. Otherwise it gives on. Sleep takes priority over standby.
- R2: In mode 00, with state on, `rail_en[0]` follows pin A (`ctl_in[1]`) and `rail_en[1]` follows pin D (`ctl_in[2]`).
- R3: In modes 10 and 11, with state on, `rail_en` follows `seq_en`. `master_en` equals the master pin (`ctl_in[0]`) in modes 10 and 11, and is 0 in modes 00 and 01.
- R4: In standby, each rail whose `cfg_stby_en` bit is set is disabled. This happens in the next output update and does not go through the sequencer. Rails with the bit clear keep following `seq_en`.
- R5: In modes 00, 01 and 10, pin A has no standby effect: `pwr_state` is never 11.
- R6: `cfg_rst_sel` picks the reset value: 001 = PG1, 011 = PG2, 101 = PG1 AND PG2. Every other code gives 0, which means reset is asserted.
- R7: Pin roles by mode. Pads use `drv_*` index 0 = A, 1 = B, 2 = C, 3 = D. In mode 00, C carries the reset value. In mode 10, A carries reset, B carries PG1 and C carries PG2. In mode 11, B carries PG1 and C carries PG2. Pin D is never driven.
- R8: For a driven pin with its `cfg_od` bit set, `drv_oe` is high only while the value is 0, and `drv_out` is 0. With the bit clear, `drv_oe` is 1 and `drv_out` equals the value. Undriven pins have `drv_oe` = 0 and `drv_out` = 0.
- R9: In the off and sleep states, `rail_en` is 0.
- R10: A change on `ctl_in` or `sleep_in` reaches the outputs on the third rising edge. A change on `uv_low`, `pg1`, `pg2`, `seq_en` or the configuration reaches them on the first edge.
- R11: In reserved mode 01, both rails are off, no pin is driven and `master_en` is 0. While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Operating mode (00 direct, 01 reserved, 10 sequenced, 11 sequenced with standby) |
| cfg_rst_sel | input | 3 | Reset boolean select |
| cfg_od | input | NUM_PADS | Open-drain select per pin A..D |
| cfg_stby_en | input | NUM_RAILS | Standby shut-off select per rail |
| ctl_in | input | NUM_INS | Pad levels: 0 master, 1 pin A, 2 pin D |
| sleep_in | input | 1 | Sleep pin level |
| uv_low | input | 1 | Supply below undervoltage threshold |
| pg1 | input | 1 | Rail 1 power good |
| pg2 | input | 1 | Rail 2 power good |
| seq_en | input | NUM_RAILS | Sequencer enable requests |
| rail_en | output | NUM_RAILS | Final rail enables |
| master_en | output | 1 | Master enable to the sequencer |
| drv_oe | output | NUM_PADS | Output-drive enables, pins A..D |
| drv_out | output | NUM_PADS | Output values, pins A..D |
| pwr_state | output | 2 | Power state code |

## Verification
The hardest situation to reach is standby. It needs mode 11, a clear undervoltage flag, a low sleep pin and a high pin A that has already passed through the synchronizer, all at the same time as a chosen mix of standby-select bits and sequencer requests. The sweep holds each combination of mode, sleep, undervoltage, pin levels, sequencer requests and standby bits for several cycles, so every path, including sleep overriding standby, settles before sampling. A second sweep walks every reset-select code, every power-good pair and every open-drain pattern in all four modes. A directed step then measures the synchronizer latency one edge at a time.

// File: rtl/pmic_pin_pkg.sv
`timescale 1ns/1ps
package pmic_pin_pkg;

   typedef enum logic [1:0] {
      PS_OFF   = 2'b00,
      PS_ON    = 2'b01,
      PS_SLEEP = 2'b10,
      PS_STBY  = 2'b11
   } pwr_state_e;

   typedef enum logic [1:0] {
      MD_PINS     = 2'b00,
      MD_RSVD     = 2'b01,
      MD_SEQ      = 2'b10,
      MD_SEQ_STBY = 2'b11
   } ctl_mode_e;

   // pad order on drv_oe / drv_out
   localparam int PAD_A = 0;
   localparam int PAD_B = 1;
   localparam int PAD_C = 2;
   localparam int PAD_D = 3;

   // order on ctl_in
   localparam int IN_MASTER = 0;
   localparam int IN_A      = 1;
   localparam int IN_D      = 2;

   function automatic logic rst_pick(input logic [2:0] sel,
                                     input logic pg_a,
                                     input logic pg_b);
      logic r;
      case (sel)
         3'b001:  r = pg_a;
         3'b011:  r = pg_b;
         3'b101:  r = pg_a & pg_b;
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pmic_sync.sv
`timescale 1ns/1ps
module pmic_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pmic_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pmic_pwr_state.sv
`timescale 1ns/1ps
module pmic_pwr_state
   import pmic_pin_pkg::*;
(
   input  ctl_mode_e  mode,
   input  logic       uv_low,
   input  logic       sleep_s,
   input  logic       stby_pin_s,
   output pwr_state_e state
);
   always_comb begin
      if (uv_low)
         state = PS_OFF;
      else if (sleep_s)
         state = PS_SLEEP;
      else if ((mode == MD_SEQ_STBY) && stby_pin_s)
         state = PS_STBY;
      else
         state = PS_ON;
   end
endmodule

// File: rtl/pmic_rail_gate.sv
`timescale 1ns/1ps
module pmic_rail_gate
   import pmic_pin_pkg::*;
#(
   parameter int NUM_RAILS = 2
) (
   input  ctl_mode_e            mode,
   input  pwr_state_e           state,
   input  logic                 pin_a_s,
   input  logic                 pin_d_s,
   input  logic [NUM_RAILS-1:0] seq_en,
   input  logic [NUM_RAILS-1:0] stby_en,
   output logic [NUM_RAILS-1:0] rails
);
   logic                 live;
   logic [NUM_RAILS-1:0] drop;

   assign live = (state == PS_ON) || (state == PS_STBY);
   assign drop = (state == PS_STBY) ? stby_en : '0;

   always_comb begin
      rails = '0;
      if (live) begin
         case (mode)
            MD_PINS:             rails = {pin_d_s, pin_a_s};
            MD_SEQ, MD_SEQ_STBY: rails = seq_en & ~drop;
            default:             rails = '0;
         endcase
      end
   end
endmodule

// File: rtl/pmic_pin_map.sv
`timescale 1ns/1ps
module pmic_pin_map
   import pmic_pin_pkg::*;
#(
   parameter int NUM_PADS = 4
) (
   input  ctl_mode_e            mode,
   input  logic                 rst_val,
   input  logic                 pg1,
   input  logic                 pg2,
   output logic [NUM_PADS-1:0]  fn_en,
   output logic [NUM_PADS-1:0]  fn_val
);
   always_comb begin
      fn_en  = '0;
      fn_val = '0;
      case (mode)
         MD_PINS: begin
            fn_en[PAD_C]  = 1'b1;
            fn_val[PAD_C] = rst_val;
         end
         MD_SEQ: begin
            fn_en[PAD_A]  = 1'b1;
            fn_val[PAD_A] = rst_val;
            fn_en[PAD_B]  = 1'b1;
            fn_val[PAD_B] = pg1;
            fn_en[PAD_C]  = 1'b1;
            fn_val[PAD_C] = pg2;
         end
         MD_SEQ_STBY: begin
            fn_en[PAD_B]  = 1'b1;
            fn_val[PAD_B] = pg1;
            fn_en[PAD_C]  = 1'b1;
            fn_val[PAD_C] = pg2;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pmic_pad_drv.sv
`timescale 1ns/1ps
module pmic_pad_drv (
   input  logic fn_en,
   input  logic fn_val,
   input  logic od_sel,
   output logic oe,
   output logic val
);
   always_comb begin
      if (od_sel) begin
         oe  = fn_en & ~fn_val;
         val = 1'b0;
      end else begin
         oe  = fn_en;
         val = fn_en & fn_val;
      end
   end
endmodule

// File: rtl/pmic_pin_ctrl.sv
`timescale 1ns/1ps
module pmic_pin_ctrl
   import pmic_pin_pkg::*;
#(
   parameter int NUM_RAILS   = 2,
   parameter int NUM_PADS    = 4,
   parameter int NUM_INS     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cfg_mode,
   input  logic [2:0]           cfg_rst_sel,
   input  logic [NUM_PADS-1:0]  cfg_od,
   input  logic [NUM_RAILS-1:0] cfg_stby_en,
   input  logic [NUM_INS-1:0]   ctl_in,
   input  logic                 sleep_in,
   input  logic                 uv_low,
   input  logic                 pg1,
   input  logic                 pg2,
   input  logic [NUM_RAILS-1:0] seq_en,
   output logic [NUM_RAILS-1:0] rail_en,
   output logic                 master_en,
   output logic [NUM_PADS-1:0]  drv_oe,
   output logic [NUM_PADS-1:0]  drv_out,
   output logic [1:0]           pwr_state
);
   localparam int SYNC_W = NUM_INS + 1;

   generate
      if (NUM_RAILS != 2) begin : g_bad_rails
         $error("pmic_pin_ctrl: pin roles are defined for two rails");
      end
      if (NUM_PADS != 4) begin : g_bad_pads
         $error("pmic_pin_ctrl: pin roles are defined for four pads");
      end
      if (NUM_INS != 3) begin : g_bad_ins
         $error("pmic_pin_ctrl: three synchronized pad inputs expected");
      end
   endgenerate

   // ---------------- input synchronization ----------------
   logic [SYNC_W-1:0] raw_in, syn_in;
   logic [NUM_INS-1:0] ctl_s;
   logic               sleep_s;

   assign raw_in = {sleep_in, ctl_in};

   pmic_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign ctl_s   = syn_in[NUM_INS-1:0];
   assign sleep_s = syn_in[NUM_INS];

   // ---------------- power state ----------------
   ctl_mode_e  mode;
   pwr_state_e st_nxt;

   assign mode = ctl_mode_e'(cfg_mode);

   pmic_pwr_state u_state (
      .mode       (mode),
      .uv_low     (uv_low),
      .sleep_s    (sleep_s),
      .stby_pin_s (ctl_s[IN_A]),
      .state      (st_nxt)
   );

   // ---------------- rail enables ----------------
   logic [NUM_RAILS-1:0] rail_nxt;

   pmic_rail_gate #(.NUM_RAILS(NUM_RAILS)) u_rails (
      .mode    (mode),
      .state   (st_nxt),
      .pin_a_s (ctl_s[IN_A]),
      .pin_d_s (ctl_s[IN_D]),
      .seq_en  (seq_en),
      .stby_en (cfg_stby_en),
      .rails   (rail_nxt)
   );

   logic master_nxt;
   assign master_nxt = cfg_mode[1] & ctl_s[IN_MASTER];

   // ---------------- pin roles and drivers ----------------
   logic                rst_val;
   logic [NUM_PADS-1:0] fn_en, fn_val;
   logic [NUM_PADS-1:0] oe_nxt, out_nxt;

   assign rst_val = rst_pick(cfg_rst_sel, pg1, pg2);

   pmic_pin_map #(.NUM_PADS(NUM_PADS)) u_map (
      .mode    (mode),
      .rst_val (rst_val),
      .pg1     (pg1),
      .pg2     (pg2),
      .fn_en   (fn_en),
      .fn_val  (fn_val)
   );

   generate
      for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
         pmic_pad_drv u_drv (
            .fn_en  (fn_en[p]),
            .fn_val (fn_val[p]),
            .od_sel (cfg_od[p]),
            .oe     (oe_nxt[p]),
            .val    (out_nxt[p])
         );
      end
   endgenerate

   // ---------------- output registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rail_en   <= '0;
         master_en <= 1'b0;
         drv_oe    <= '0;
         drv_out   <= '0;
         pwr_state <= PS_OFF;
      end else begin
         rail_en   <= rail_nxt;
         master_en <= master_nxt;
         drv_oe    <= oe_nxt;
         drv_out   <= out_nxt;
         pwr_state <= st_nxt;
      end
   end
endmodule

// File: rtl/pmic_pin_ctrl_chk.sv
`timescale 1ns/1ps
module pmic_pin_ctrl_chk #(
   parameter int NUM_RAILS = 2,
   parameter int NUM_PADS  = 4,
   parameter int NUM_INS   = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           cfg_mode,
   input logic [2:0]           cfg_rst_sel,
   input logic [NUM_PADS-1:0]  cfg_od,
   input logic [NUM_RAILS-1:0] cfg_stby_en,
   input logic [NUM_INS-1:0]   ctl_in,
   input logic                 sleep_in,
   input logic                 uv_low,
   input logic                 pg1,
   input logic                 pg2,
   input logic [NUM_RAILS-1:0] seq_en,
   input logic [NUM_RAILS-1:0] rail_en,
   input logic                 master_en,
   input logic [NUM_PADS-1:0]  drv_oe,
   input logic [NUM_PADS-1:0]  drv_out,
   input logic [1:0]           pwr_state
);
   // R1: undervoltage forces the off code on the next edge
   p_uv_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      uv_low |=> (pwr_state == 2'b00));

   // R9: no rail enabled in off or sleep
   p_rails_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b00 || pwr_state == 2'b10) |-> (rail_en == '0));

   // R5: standby code only reachable in mode 11
   p_no_stby_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'b11) |=> (pwr_state != 2'b11));

   // R6: reserved select codes hold reset low on pin C in mode 00
   p_rst_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_mode == 2'b00) && (cfg_rst_sel != 3'b001) && (cfg_rst_sel != 3'b011)
       && (cfg_rst_sel != 3'b101)) |=> !drv_out[2]);

   // R7: pin B carries PG1 in sequenced modes when push-pull
   p_pg_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode[1] && !cfg_od[1]) |=> (drv_oe[1] && (drv_out[1] == $past(pg1))));

   // R11: reserved mode drives nothing and enables nothing
   p_rsvd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'b01) |=> ((drv_oe == '0) && (rail_en == '0) && !master_en));

   // R8: an open-drain pin never drives high
   generate
      for (genvar p = 0; p < NUM_PADS; p++) begin : g_od
         p_od_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cfg_od[p]) && drv_oe[p]) |-> !drv_out[p]);
      end
   endgenerate
endmodule

bind pmic_pin_ctrl pmic_pin_ctrl_chk #(
   .NUM_RAILS (NUM_RAILS),
   .NUM_PADS  (NUM_PADS),
   .NUM_INS   (NUM_INS)
) u_chk (.*);

// File: tb/sim_pmic_pin_ctrl.sv
`timescale 1ns/1ps
module sim_pmic_pin_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic [2:0] cfg_rst_sel = 3'b000;
   logic [3:0] cfg_od = 4'b0000;
   logic [1:0] cfg_stby_en = 2'b00;
   logic [2:0] ctl_in = 3'b000;
   logic       sleep_in = 1'b0;
   logic       uv_low = 1'b0;
   logic       pg1 = 1'b0;
   logic       pg2 = 1'b0;
   logic [1:0] seq_en = 2'b00;
   logic [1:0] rail_en;
   logic       master_en;
   logic [3:0] drv_oe, drv_out;
   logic [1:0] pwr_state;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pmic_pin_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_rst_sel(cfg_rst_sel),
      .cfg_od(cfg_od), .cfg_stby_en(cfg_stby_en), .ctl_in(ctl_in),
      .sleep_in(sleep_in), .uv_low(uv_low), .pg1(pg1), .pg2(pg2),
      .seq_en(seq_en), .rail_en(rail_en), .master_en(master_en),
      .drv_oe(drv_oe), .drv_out(drv_out), .pwr_state(pwr_state)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (mode=%0d rsel=%0d od=%0h)",
                  tag, act, exp, cfg_mode, cfg_rst_sel, cfg_od);
      end
   endtask

   // model built from the requirements
   logic [1:0] e_state, e_rail;
   logic       e_master, e_rst;
   logic [3:0] e_oe, e_out, f_en, f_val;

   task automatic predict();
      if (uv_low)                                 e_state = 2'b00;
      else if (sleep_in)                          e_state = 2'b10;
      else if (cfg_mode == 2'b11 && ctl_in[1])    e_state = 2'b11;
      else                                        e_state = 2'b01;
      case (cfg_rst_sel)
         3'd1: e_rst = pg1;
         3'd3: e_rst = pg2;
         3'd5: e_rst = pg1 & pg2;
         default: e_rst = 1'b0;
      endcase
      e_rail = 2'b00;
      if (e_state == 2'b01 || e_state == 2'b11) begin
         if (cfg_mode == 2'b00) e_rail = {ctl_in[2], ctl_in[1]};
         else if (cfg_mode[1]) e_rail = seq_en & ~((e_state == 2'b11) ? cfg_stby_en : 2'b00);
      end
      e_master = cfg_mode[1] & ctl_in[0];
      f_en = 4'b0; f_val = 4'b0;
      case (cfg_mode)
         2'b00: begin f_en = 4'b0100; f_val[2] = e_rst; end
         2'b10: begin f_en = 4'b0111; f_val[0] = e_rst; f_val[1] = pg1; f_val[2] = pg2; end
         2'b11: begin f_en = 4'b0110; f_val[1] = pg1; f_val[2] = pg2; end
         default: ;
      endcase
      for (int p = 0; p < 4; p++) begin
         if (cfg_od[p]) begin e_oe[p] = f_en[p] & ~f_val[p]; e_out[p] = 1'b0; end
         else begin e_oe[p] = f_en[p]; e_out[p] = f_en[p] & f_val[p]; end
      end
   endtask

   task automatic settle_and_check();
      repeat (4) @(posedge clk);
      @(negedge clk);
      predict();
      chk((cfg_mode == 2'b11) ? "R1 pwr_state" : "R1 R5 pwr_state", pwr_state, e_state);
      if (e_state == 2'b00 || e_state == 2'b10)  chk("R9 rail_en", rail_en, e_rail);
      else if (cfg_mode == 2'b00)                chk("R2 rail_en", rail_en, e_rail);
      else if (cfg_mode == 2'b01)                chk("R11 rail_en", rail_en, e_rail);
      else if (e_state == 2'b11)                 chk("R4 rail_en", rail_en, e_rail);
      else                                       chk("R3 rail_en", rail_en, e_rail);
      chk("R3 master_en", master_en, e_master);
      chk((cfg_mode == 2'b01) ? "R11 drv_oe" : "R7 R8 drv_oe", drv_oe, e_oe);
      chk("R6 R7 R8 drv_out", drv_out, e_out);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 reset rail_en", rail_en, 0);
      chk("R11 reset drv_oe", drv_oe, 0);
      chk("R11 reset pwr_state", pwr_state, 0);
      chk("R11 reset master_en", master_en, 0);
      rst_n = 1'b1;

      // sweep 1: state, rails, standby
      cfg_rst_sel = 3'd5;
      cfg_od = 4'b0101;
      for (int i = 0; i < 2048; i++) begin
         @(negedge clk);
         cfg_mode    = i[1:0];
         sleep_in    = i[2];
         uv_low      = i[3];
         ctl_in      = i[6:4];
         seq_en      = i[8:7];
         cfg_stby_en = i[10:9];
         pg1         = i[4] ^ i[7];
         pg2         = i[5] ^ i[8];
         settle_and_check();
      end

      // sweep 2: reset select, power-good flags, open-drain patterns
      uv_low = 1'b0; sleep_in = 1'b0; ctl_in = 3'b101; seq_en = 2'b11;
      cfg_stby_en = 2'b00;
      for (int i = 0; i < 2048; i++) begin
         @(negedge clk);
         cfg_mode    = i[1:0];
         cfg_rst_sel = i[4:2];
         pg1         = i[5];
         pg2         = i[6];
         cfg_od      = i[10:7];
         settle_and_check();
      end

      // R10: latency of synchronized and direct inputs
      @(negedge clk);
      cfg_mode = 2'b00; ctl_in = 3'b110; sleep_in = 1'b0; uv_low = 1'b0;
      settle_and_check();
      sleep_in = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R10 sleep after two edges", pwr_state, 2'b01);
      @(posedge clk);
      @(negedge clk);
      chk("R10 sleep after three edges", pwr_state, 2'b10);
      chk("R10 R9 rails in sleep", rail_en, 2'b00);
      sleep_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 wake", pwr_state, 2'b01);
      uv_low = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R10 uv after one edge", pwr_state, 2'b00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule